// File: doc/BRIEF.md
# Shared-Medium Transmit Backoff Controller

This block decides when a transmitter on a shared, collision-prone medium may put a frame on the wire. An upper layer raises a frame request. The controller first waits for the medium to be quiet. It then waits a further fixed defer interval and grants transmission. While the frame is on the wire it watches for collisions. A collision makes the controller hold the transmitter on for a short jam burst, measured in byte times. It then releases the medium and draws a random backoff before it tries again.

The backoff is a whole number of slot times. The multiplier is drawn from a free-running pseudo-random register and masked to a width that grows with the number of collisions so far. That width stops growing at a parameterised cap. Once the configured number of attempts has been used up, the frame is given up and the upper layer sees a one-cycle failure strobe. A clean end of frame gives a one-cycle completion strobe and clears the attempt count. Frame serialisation, checksums and line coding belong to the neighbouring blocks.

Top module: `mac_backoff_ctrl`

## Requirements
- R1: While reset is active, and after reset until a request arrives, `tx_en`, `jam`, `done` and `fail` are all low.
- R2: A request is accepted on the first clock edge that samples `frame_req` high while the controller is idle. `tx_en` rises immediately after the DEFER_CYC-th following edge, provided every one of those edges samples `carrier` low.
- R3: Any edge that samples `carrier` high during the defer wait restarts it. `tx_en` then rises only after DEFER_CYC further consecutive edges sample `carrier` low, and it never rises just after a cycle in which `carrier` was high.
- R4: A `collision` sampled while transmitting makes `jam` rise after that edge while `tx_en` stays high. `jam` stays high until exactly JAM_BYTES `byte_tick` pulses have been sampled with `jam` high, and then `jam` and `tx_en` fall on the same edge.
- R5: After collision number n of a frame, `tx_en` rises again exactly 1 + R*SLOT_CYC + DEFER_CYC cycles after `jam` falls (medium idle). R is an integer with 0 <= R < 2^min(n, EXP_CAP). R is taken from the low bits of a 16-bit maximal-length shift register that advances every clock, so R varies between attempts.
- R6: If `collision` and `tx_end` are sampled high on the same edge while transmitting, the collision wins: jam and backoff follow, and `done` does not pulse.
- R7: `collision` and `tx_end` have no effect unless the controller is transmitting. Pulsing them while idle or during the defer wait changes neither the timing of `tx_en` nor `jam`.
- R8: When the jam of collision number MAX_TRIES (16 by default) ends, `fail` pulses for one cycle on the same edge that `jam` and `tx_en` fall. No retry follows, and the next frame starts again from collision number 1.
- R9: A `tx_end` sampled while transmitting with no collision drops `tx_en` and pulses `done` for exactly one cycle on that edge. The attempt count returns to zero, so the next frame's first collision uses exponent 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_req | input | 1 | Upper layer holds a frame ready (level) |
| carrier | input | 1 | Medium sensed busy |
| collision | input | 1 | Collision detected on the medium |
| tx_end | input | 1 | Serialiser reports the last byte of the frame sent |
| byte_tick | input | 1 | One-cycle pulse per byte time |
| tx_en | output | 1 | Transmitter may drive the medium (frame or jam) |
| jam | output | 1 | Transmitter must send the jam pattern |
| done | output | 1 | One-cycle strobe: frame sent successfully |
| fail | output | 1 | One-cycle strobe: frame abandoned after the last attempt |

## Verification
Two events can land in the same cycle. One is a collision arriving on the very cycle the serialiser reports the end of the frame, which puts a jam and a completion in competition. The other is the final jam ending together with the give-up decision. The bench raises `collision` and `tx_end` on the same falling edge while `tx_en` is high. The scoreboard then expects a jam followed by a backoff-timed retry and treats any `done` as an unexpected event. For the give-up case, it expects `fail` on exactly the cycle where `jam` falls and no later rise of `tx_en`.

// File: rtl/mac_bo_pkg.sv
package mac_bo_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_DEFER   = 3'd1,
      ST_XMIT    = 3'd2,
      ST_JAM     = 3'd3,
      ST_BACKOFF = 3'd4
   } bo_state_e;

   // counter width that is never zero
   function automatic int cnt_w(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/mac_bo_prng.sv
module mac_bo_prng #(
   parameter int          WIDTH = 16,
   parameter logic [31:0] SEED  = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] state
);

   logic [WIDTH-1:0] taps;
   logic             fb;

   generate
      if (WIDTH == 16) begin : g_w16
         assign taps = 16'hB400;
      end else if (WIDTH == 32) begin : g_w32
         assign taps = 32'h8020_0003;
      end else begin : g_wbad
         $error("mac_bo_prng: WIDTH must be 16 or 32");
         assign taps = '0;
      end
      if (SEED[WIDTH-1:0] == '0) begin : g_seed_bad
         $error("mac_bo_prng: SEED must be non-zero");
      end
   endgenerate

   assign fb = ^(state & taps);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEED[WIDTH-1:0];
      else        state <= {state[WIDTH-2:0], fb};
   end

endmodule

// File: rtl/mac_bo_defer_timer.sv
module mac_bo_defer_timer #(
   parameter int DEFER_CYC = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic carrier,
   output logic elapsed
);
   import mac_bo_pkg::*;

   localparam int DW = cnt_w(DEFER_CYC);
   localparam logic [DW-1:0] LAST = DW'(DEFER_CYC - 1);

   logic [DW-1:0] cnt_q;

   assign elapsed = active && !carrier && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (!active || carrier)  cnt_q <= '0;
      else if (cnt_q != LAST)       cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/mac_bo_slot_timer.sv
module mac_bo_slot_timer #(
   parameter int SLOT_CYC = 128,
   parameter int MULT_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MULT_W-1:0] load_val,
   input  logic              active,
   output logic              expired
);
   import mac_bo_pkg::*;

   logic [MULT_W-1:0] slots_q;
   logic              slot_wrap;

   generate
      if (SLOT_CYC == 1) begin : g_single
         // every cycle is one slot
         assign slot_wrap = 1'b1;
      end else begin : g_multi
         localparam int TW = cnt_w(SLOT_CYC);
         localparam logic [TW-1:0] TLAST = TW'(SLOT_CYC - 1);
         logic [TW-1:0] tick_q;
         assign slot_wrap = (tick_q == TLAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          tick_q <= '0;
            else if (load)                       tick_q <= '0;
            else if (active && slots_q != '0) begin
               if (slot_wrap) tick_q <= '0;
               else           tick_q <= tick_q + 1'b1;
            end
         end
      end
   endgenerate

   assign expired = active && (slots_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      slots_q <= '0;
      else if (load)                                   slots_q <= load_val;
      else if (active && slots_q != '0 && slot_wrap)   slots_q <= slots_q - 1'b1;
   end

endmodule

// File: rtl/mac_backoff_ctrl.sv
module mac_backoff_ctrl #(
   parameter int          DEFER_CYC = 24,
   parameter int          SLOT_CYC  = 128,
   parameter int          JAM_BYTES = 4,
   parameter int          MAX_TRIES = 16,
   parameter int          EXP_CAP   = 10,
   parameter int          LFSR_W    = 16,
   parameter logic [31:0] LFSR_SEED = 32'h0000_ACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_req,
   input  logic carrier,
   input  logic collision,
   input  logic tx_end,
   input  logic byte_tick,
   output logic tx_en,
   output logic jam,
   output logic done,
   output logic fail
);
   import mac_bo_pkg::*;

   localparam int ATT_W = $clog2(MAX_TRIES + 1);
   localparam int JAM_W = cnt_w(JAM_BYTES);
   localparam int R_W   = EXP_CAP;

   generate
      if (JAM_BYTES < 4 || JAM_BYTES > 6) begin : g_chk_jam
         $error("mac_backoff_ctrl: JAM_BYTES must lie in 4..6");
      end
      if (EXP_CAP < 1 || EXP_CAP > LFSR_W) begin : g_chk_cap
         $error("mac_backoff_ctrl: EXP_CAP must lie in 1..LFSR_W");
      end
      if (MAX_TRIES < 2) begin : g_chk_tries
         $error("mac_backoff_ctrl: MAX_TRIES must be at least 2");
      end
      if (DEFER_CYC < 1 || SLOT_CYC < 1) begin : g_chk_time
         $error("mac_backoff_ctrl: DEFER_CYC and SLOT_CYC must be positive");
      end
   endgenerate

   bo_state_e         state_q, state_d;
   logic [ATT_W-1:0]  attempts_q;
   logic [JAM_W-1:0]  jam_cnt_q;
   logic              done_q, fail_q;

   logic [LFSR_W-1:0] rnd;
   logic [R_W-1:0]    r_mask, r_draw;
   logic              defer_ok, backoff_over;
   logic              jam_last, give_up, hit, clean_end;

   mac_bo_prng #(.WIDTH(LFSR_W), .SEED(LFSR_SEED)) u_prng (
      .clk   (clk),
      .rst_n (rst_n),
      .state (rnd)
   );

   mac_bo_defer_timer #(.DEFER_CYC(DEFER_CYC)) u_defer (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (state_q == ST_DEFER),
      .carrier (carrier),
      .elapsed (defer_ok)
   );

   mac_bo_slot_timer #(.SLOT_CYC(SLOT_CYC), .MULT_W(R_W)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (jam_last && !give_up),
      .load_val (r_draw),
      .active   (state_q == ST_BACKOFF),
      .expired  (backoff_over)
   );

   // exponent follows the collision count, capped at EXP_CAP
   always_comb begin
      if (int'(attempts_q) >= EXP_CAP) r_mask = '1;
      else                             r_mask = ~({R_W{1'b1}} << attempts_q);
   end
   assign r_draw = rnd[R_W-1:0] & r_mask;

   assign hit       = (state_q == ST_XMIT) && collision;
   assign clean_end = (state_q == ST_XMIT) && !collision && tx_end;
   assign jam_last  = (state_q == ST_JAM) && byte_tick &&
                      (jam_cnt_q == JAM_W'(JAM_BYTES - 1));
   assign give_up   = (attempts_q == ATT_W'(MAX_TRIES));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (frame_req)    state_d = ST_DEFER;
         ST_DEFER:   if (defer_ok)     state_d = ST_XMIT;
         ST_XMIT: begin
            if (collision)             state_d = ST_JAM;
            else if (tx_end)           state_d = ST_IDLE;
         end
         ST_JAM:     if (jam_last)     state_d = give_up ? ST_IDLE : ST_BACKOFF;
         ST_BACKOFF: if (backoff_over) state_d = ST_DEFER;
         default:                      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         attempts_q <= '0;
         jam_cnt_q  <= '0;
         done_q     <= 1'b0;
         fail_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= clean_end;
         fail_q  <= jam_last && give_up;

         if (hit)                              attempts_q <= attempts_q + 1'b1;
         else if (clean_end || (jam_last && give_up)) attempts_q <= '0;

         if (state_q != ST_JAM)  jam_cnt_q <= '0;
         else if (byte_tick)     jam_cnt_q <= jam_cnt_q + 1'b1;
      end
   end

   assign tx_en = (state_q == ST_XMIT) || (state_q == ST_JAM);
   assign jam   = (state_q == ST_JAM);
   assign done  = done_q;
   assign fail  = fail_q;

endmodule

// File: rtl/mac_backoff_ctrl_chk.sv
module mac_backoff_ctrl_chk #(
   parameter int MAX_TRIES = 16,
   parameter int ATT_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             carrier,
   input logic             collision,
   input logic             tx_en,
   input logic             jam,
   input logic             done,
   input logic             fail,
   input logic [ATT_W-1:0] attempts
);

   AST_TX_ON_IDLE_MEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> !$past(carrier)); // R3

   AST_JAM_HOLDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      jam |-> tx_en); // R4

   AST_JAM_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam) |-> ($past(collision) && $past(tx_en))); // R7

   AST_DONE_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(tx_en) && !$past(jam) && !tx_en)); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_FAIL_ENDS_JAM: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> ($past(jam) && !tx_en && !jam)); // R8

   AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> !fail); // R8

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(attempts) <= MAX_TRIES); // R8

   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail)); // R6

endmodule

bind mac_backoff_ctrl mac_backoff_ctrl_chk #(
   .MAX_TRIES (MAX_TRIES),
   .ATT_W     (ATT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .carrier   (carrier),
   .collision (collision),
   .tx_en     (tx_en),
   .jam       (jam),
   .done      (done),
   .fail      (fail),
   .attempts  (attempts_q)
);

// File: tb/mac_backoff_ctrl_test.sv
module mac_backoff_ctrl_test;

   localparam int D = 6;
   localparam int S = 4;
   localparam int J = 4;
   localparam int M = 16;
   localparam int E = 10;

   localparam int EV_TX   = 0;
   localparam int EV_TXB  = 1;
   localparam int EV_JAM  = 2;
   localparam int EV_DONE = 3;
   localparam int EV_FAIL = 4;

   typedef struct {
      int    kind;
      int    cyc;
      int    k;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_req = 1'b0, carrier = 1'b0, collision = 1'b0, tx_end = 1'b0;
   logic byte_tick = 1'b0;
   logic tx_en, jam, done, fail;

   int   cyc = 0;
   int   nchk = 0, nerr = 0;
   int   jf = -1, jam_ticks = 0, nzr = 0, bt_cnt = 0;
   logic p_tx = 1'b0, p_jam = 1'b0;
   exp_t sbq[$];

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      bt_cnt = (bt_cnt + 1) % 4;
      byte_tick = (bt_cnt == 0);
   end

   mac_backoff_ctrl #(
      .DEFER_CYC (D), .SLOT_CYC (S), .JAM_BYTES (J),
      .MAX_TRIES (M), .EXP_CAP (E)
   ) uut (
      .clk (clk), .rst_n (rst_n), .frame_req (frame_req), .carrier (carrier),
      .collision (collision), .tx_end (tx_end), .byte_tick (byte_tick),
      .tx_en (tx_en), .jam (jam), .done (done), .fail (fail)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic void push(input int kind, input int c, input int k, input string tag);
      exp_t e;
      e.kind = kind; e.cyc = c; e.k = k; e.tag = tag;
      sbq.push_back(e);
   endfunction

   // monitor side of the scoreboard
   task automatic take(input int kind);
      exp_t e;
      int   r;
      if (sbq.size() == 0) begin
         chk(1'b0, "R7", "unexpected event kind", kind, -1);
         return;
      end
      e = sbq.pop_front();
      chk(e.kind == kind || (e.kind == EV_TXB && kind == EV_TX), e.tag, "event kind", kind, e.kind);
      case (e.kind)
         EV_TXB: begin
            r = cyc - jf - 1 - D;
            chk(r >= 0 && (r % S) == 0 && (r / S) < (1 << e.k), e.tag,
                "backoff cycles (expected: multiple of slot below bound)", r, (1 << e.k) * S);
            if (r > 0) nzr++;
         end
         EV_FAIL: chk(cyc == jf, e.tag, "fail cycle vs jam end", cyc, jf);
         default: chk(cyc == e.cyc, e.tag, "event cycle", cyc, e.cyc);
      endcase
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         p_tx  = 1'b0;
         p_jam = 1'b0;
      end else begin
         if (!p_jam && jam) begin
            jam_ticks = 0;
            take(EV_JAM);
         end
         if (jam && byte_tick) jam_ticks++;
         if (p_jam && !jam) begin
            jf = cyc;
            chk(jam_ticks == J, "R4", "jam length in byte ticks", jam_ticks, J);
            chk(!tx_en, "R4", "tx_en falls with jam", int'(tx_en), 0);
         end
         if (!p_tx && tx_en) take(EV_TX);
         if (done) take(EV_DONE);
         if (fail) take(EV_FAIL);
         p_tx  = tx_en;
         p_jam = jam;
      end
   end

   // ---------------- driver ----------------
   task automatic wait_tx();
      do @(negedge clk); while (!(tx_en && !jam));
   endtask

   task automatic collide(input int n, input string tag);
      push(EV_JAM, cyc + 1, 0, tag);
      if (n >= M) push(EV_FAIL, 0, 0, "R8");
      else        push(EV_TXB, 0, (n < E) ? n : E, "R5");
      collision = 1'b1;
      @(negedge clk);
      collision = 1'b0;
   endtask

   task automatic finish_ok(input string tag);
      wait_tx();
      repeat (2) @(negedge clk);
      push(EV_DONE, cyc + 1, 0, tag);
      tx_end = 1'b1;
      @(negedge clk);
      tx_end = 1'b0;
      frame_req = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send(input int ncoll, input string tag);
      @(negedge clk);
      frame_req = 1'b1;
      push(EV_TX, cyc + 1 + D, 0, tag);
      for (int i = 1; i <= ncoll; i++) begin
         wait_tx();
         repeat (2) @(negedge clk);
         collide(i, "R4");
      end
      if (ncoll >= M) begin
         do @(negedge clk); while (!fail);
         frame_req = 1'b0;
         repeat (3) @(negedge clk);
      end else begin
         finish_ok("R9");
      end
   endtask

   initial begin
      int c;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk({tx_en, jam, done, fail} == 4'b0, "R1", "outputs in reset", int'({tx_en, jam, done, fail}), 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk({tx_en, jam, done, fail} == 4'b0, "R1", "outputs idle after reset", int'({tx_en, jam, done, fail}), 0);

      // R2: plain frame, exact defer
      send(0, "R2");

      // R3: busy medium, then a blip inside the defer window
      @(negedge clk);
      carrier = 1'b1;
      frame_req = 1'b1;
      repeat (5) @(negedge clk);
      carrier = 1'b0;
      repeat (3) @(negedge clk);
      carrier = 1'b1;
      repeat (2) @(negedge clk);
      carrier = 1'b0;
      c = cyc;
      push(EV_TX, c + D, 0, "R3");
      finish_ok("R9");

      // R7: collision / end-of-frame outside transmission
      @(negedge clk);
      collision = 1'b1; tx_end = 1'b1;
      @(negedge clk);
      collision = 1'b0; tx_end = 1'b0;
      frame_req = 1'b1;
      push(EV_TX, cyc + 1 + D, 0, "R7");
      repeat (2) @(negedge clk);
      collision = 1'b1; tx_end = 1'b1;
      @(negedge clk);
      collision = 1'b0; tx_end = 1'b0;
      finish_ok("R9");

      // R4/R5: several collisions, then success
      send(3, "R5");

      // R6: collision and end of frame in the same cycle
      @(negedge clk);
      frame_req = 1'b1;
      push(EV_TX, cyc + 1 + D, 0, "R6");
      wait_tx();
      repeat (2) @(negedge clk);
      push(EV_JAM, cyc + 1, 0, "R6");
      push(EV_TXB, 0, 1, "R6");
      collision = 1'b1; tx_end = 1'b1;
      @(negedge clk);
      collision = 1'b0; tx_end = 1'b0;
      finish_ok("R6");

      // R9: attempt count cleared by success
      send(5, "R9");
      for (int f = 0; f < 4; f++) send(1, "R9");

      // R8: give up after the last attempt, exponent capped (R5)
      send(M, "R8");
      for (int f = 0; f < 3; f++) send(1, "R8");

      repeat (10) @(negedge clk);
      chk(sbq.size() == 0, "R9", "pending expected events", sbq.size(), 0);
      chk(nzr > 0, "R5", "backoff draws above zero", nzr, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(20 * 180000);
      nchk++;
      nerr++;
      $display("FAIL watchdog R8: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule